// File: doc/BRIEF.md
# Serial Transmitter with Alternating Bit Lengths

This block sends bytes on an asynchronous serial line. The bit period has two parts. A prescaler divides the system clock by a programmable count to make timing ticks. A short select field then sets how many ticks make up each bit. Three selections use a fixed 15, 16 or 17 ticks for every bit. Two more selections alternate between neighbouring counts, bit by bit, so the average bit length lands on 15.5 or 16.5 ticks. This gives a finer choice of baud rate without a fractional divider.

A producer hands over a byte through a valid/ready handshake. The divider, tick selection, parity option and stop-length option are captured at the moment of acceptance. Each frame has these fields, in this order:
- a low start bit,
- eight data bits, least significant first,
- an optional even-parity bit,
- one or two high stop bits.

The line rests high between frames. The next byte is taken only after the final stop bit has run its full length.

Top module: `frac_bit_uart_tx`

## Requirements
- R1: After reset, `txLine` is 1 and `inReady` is 1.
- R2: A byte is accepted on a rising clock edge where `inValid` and `inReady` are both 1. `inReady` is 0 from the next cycle until the last stop bit ends, and it returns to 1 in the cycle right after that.
- R3: The frame begins in the cycle after acceptance. It has a 0 start bit, then the data bits with bit 0 first, then any parity bit, then the stop bits. Stop bits are 1.
- R4: When `parityEn` is 1, a parity bit follows the data and equals the XOR of the eight data bits (even parity). When `parityEn` is 0, no parity bit is sent.
- R5: When `twoStop` is 0, one stop bit is sent. When `twoStop` is 1, two stop bits are sent.
- R6: A tick lasts `divVal`+1 clock cycles. A bit of n ticks lasts n×(`divVal`+1) cycles. For example, a 4 MHz clock with `divVal`=6 and 15 ticks per bit gives 4e6/105, about 38095 bit/s.
- R7: `tickSel` 3'b000 gives 16 ticks per bit, 3'b010 gives 15, and 3'b100 gives 17. These counts apply to every bit of the frame.
- R8: `tickSel` 3'b001 gives 16 ticks to frame positions 0, 2, 4 and so on, and 17 ticks to positions 1, 3, 5 and so on. Position 0 is the start bit. The count runs on through the parity and stop bits.
- R9: `tickSel` 3'b011 gives 15 ticks to even frame positions and 16 ticks to odd ones, counted the same way as in R8.
- R10: `tickSel` values 3'b101, 3'b110 and 3'b111 behave exactly as 3'b000.
- R11: Changes to `divVal`, `tickSel`, `parityEn`, `twoStop` or `inData` while a frame is in progress have no effect on that frame.
- R12: `inValid` raised while `inReady` is 0 starts no extra frame and does not disturb the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divVal | input | 8 | Prescaler value; tick period is divVal+1 cycles |
| tickSel | input | 3 | Ticks-per-bit pattern select |
| parityEn | input | 1 | Append an even-parity bit |
| twoStop | input | 1 | Send two stop bits instead of one |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | Producer offers a byte |
| inReady | output | 1 | Transmitter can accept a byte |
| txLine | output | 1 | Serial output, high when idle |

## Verification
A wrong tick count or a wrong frame position makes one bit too long or too short. Every bit edge after that shifts by a whole number of ticks. This shows up at `txLine` in the first cycle of the next bit, and it also moves the return of `inReady`. A corrupted shift register shows the wrong level in the affected bit's first cycle. A config register that is not held shows up as a wrong bit length or a missing or extra parity or stop bit, later in the same frame. The bench checks every cycle of every bit against a schedule it computes itself, so each of these errors is caught within one bit period of its cause.

// File: rtl/fbtx_pkg.sv
package fbtx_pkg;
  localparam int TICK_W = 5;

  typedef struct packed {
    logic load;    // byte accepted this cycle
    logic shift;   // current bit ends this cycle
    logic active;  // frame in progress
  } fbtx_strb_t;

  // Ticks for one bit, from the pattern select and the parity of the frame position.
  function automatic logic [TICK_W-1:0] ticks_per_bit(input logic [2:0] sel, input logic oddPos);
    logic [TICK_W-1:0] n;
    case (sel)
      3'b001:  n = oddPos ? TICK_W'(17) : TICK_W'(16);
      3'b010:  n = TICK_W'(15);
      3'b011:  n = oddPos ? TICK_W'(16) : TICK_W'(15);
      3'b100:  n = TICK_W'(17);
      default: n = TICK_W'(16);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/fbtx_ctrl.sv
module fbtx_ctrl
  import fbtx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 3,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  logic [SEL_W-1:0] tickSel,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic             inValid,
  output logic             inReady,
  output logic             tickPulse,
  output fbtx_strb_t       strb
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divReg;
  logic [DIV_W-1:0]  preCnt;
  logic [SEL_W-1:0]  selReg;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  lastPos;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] bitLen;
  logic              accept;
  logic              bitEnd;
  logic              frameEnd;

  assign accept    = inValid && (state == ST_IDLE);
  assign tickPulse = (state == ST_SEND) && (preCnt == divReg);
  assign bitLen    = ticks_per_bit(3'(selReg), pos[0]);
  assign bitEnd    = tickPulse && (tickCnt == bitLen - TICK_W'(1));
  assign frameEnd  = bitEnd && (pos == lastPos);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divReg  <= '0;
      preCnt  <= '0;
      selReg  <= '0;
      pos     <= '0;
      lastPos <= '0;
      tickCnt <= '0;
    end else if (accept) begin
      state   <= ST_SEND;
      divReg  <= divVal;
      selReg  <= tickSel;
      lastPos <= POS_W'(9) + POS_W'(parityEn) + POS_W'(twoStop);
      preCnt  <= '0;
      tickCnt <= '0;
      pos     <= '0;
    end else if (state == ST_SEND) begin
      preCnt <= tickPulse ? '0 : preCnt + DIV_W'(1);
      if (bitEnd) begin
        tickCnt <= '0;
        pos     <= pos + POS_W'(1);
        if (frameEnd) state <= ST_IDLE;
      end else if (tickPulse) begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end

  assign inReady     = (state == ST_IDLE);
  assign strb.load   = accept;
  assign strb.shift  = bitEnd;
  assign strb.active = (state == ST_SEND);
endmodule

// File: rtl/fbtx_datapath.sv
module fbtx_datapath
  import fbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              parityEn,
  input  fbtx_strb_t        strb,
  output logic              txLine
);
  localparam int FRAME_W = DATA_W + 4;

  logic [FRAME_W-1:0] frameSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '1;
    end else if (strb.load) begin
      frameSr <= parityEn ? {2'b11, ^inData, inData, 1'b0}
                          : {3'b111, inData, 1'b0};
    end else if (strb.shift) begin
      frameSr <= {1'b1, frameSr[FRAME_W-1:1]};
    end
  end

  assign txLine = strb.active ? frameSr[0] : 1'b1;
endmodule

// File: rtl/frac_bit_uart_tx.sv
module frac_bit_uart_tx
  import fbtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [SEL_W-1:0]  tickSel,
  input  logic              parityEn,
  input  logic              twoStop,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              txLine
);
  localparam int POS_W = $clog2(DATA_W + 4);

  fbtx_strb_t strb;
  logic       tickPulse;

  fbtx_ctrl #(.DIV_W(DIV_W), .SEL_W(SEL_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divVal(divVal), .tickSel(tickSel),
    .parityEn(parityEn), .twoStop(twoStop), .inValid(inValid),
    .inReady(inReady), .tickPulse(tickPulse), .strb(strb)
  );

  fbtx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .parityEn(parityEn),
    .strb(strb), .txLine(txLine)
  );
endmodule

// File: rtl/frac_bit_uart_tx_chk.sv
module frac_bit_uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic txLine,
  input logic tickPulse
);
  // R1: the line rests high whenever a byte can be taken
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txLine);

  // R2: ready drops in the cycle after an accepted byte
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R3: the start bit appears in the cycle after acceptance
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txLine);

  // R5: ready returns only after a high stop bit
  p_ready_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(txLine));

  // R6: the line moves only after a tick or an acceptance
  p_edge_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> ($past(tickPulse) || $past(inValid && inReady)));
endmodule

bind frac_bit_uart_tx frac_bit_uart_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .txLine(txLine), .tickPulse(tickPulse)
);

// File: tb/frac_bit_uart_tx_tb.sv
module frac_bit_uart_tx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divVal = '0;
  logic [2:0] tickSel = '0;
  logic       parityEn = 1'b0;
  logic       twoStop = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       txLine;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  frac_bit_uart_tx u_dut (
    .clk(clk), .rstN(rstN), .divVal(divVal), .tickSel(tickSel),
    .parityEn(parityEn), .twoStop(twoStop), .inData(inData),
    .inValid(inValid), .inReady(inReady), .txLine(txLine)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Ticks per bit from R7..R10
  function automatic int expTicks(input logic [2:0] sel, input int p);
    case (sel)
      3'b001:  return (p % 2 == 1) ? 17 : 16;
      3'b010:  return 15;
      3'b011:  return (p % 2 == 1) ? 16 : 15;
      3'b100:  return 17;
      default: return 16;
    endcase
  endfunction

  // Sends one byte and checks every cycle of the frame; disturb exercises R11/R12.
  task automatic sendFrame(input logic [7:0] d, input logic [2:0] sel, input logic [7:0] dv,
                           input bit par, input bit two, input bit disturb, input string tag);
    int nb;
    logic expBit;
    nb = 10 + int'(par) + int'(two);
    @(negedge clk);
    divVal = dv; tickSel = sel; parityEn = par; twoStop = two; inData = d; inValid = 1'b1;
    check(inReady == 1'b1, {tag, " R2 ready before send"}, int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    for (int p = 0; p < nb; p++) begin
      int  len;
      bit  bad;
      int  badAct;
      string role;
      len = expTicks(sel, p) * (int'(dv) + 1);
      if (p == 0) begin expBit = 1'b0; role = "R3 start"; end
      else if (p <= 8) begin expBit = d[p-1]; role = "R3 data"; end
      else if (par && p == 9) begin expBit = ^d; role = "R4 parity"; end
      else begin expBit = 1'b1; role = "R5 stop"; end
      bad = 1'b0; badAct = 0;
      for (int c = 0; c < len; c++) begin
        if (!bad && (txLine !== expBit || inReady !== 1'b0)) begin
          bad = 1'b1;
          badAct = (inReady !== 1'b0) ? 2 + int'(txLine) : int'(txLine);
        end
        if (disturb && p == 1 && c == 0) begin
          divVal = dv + 8'd3; tickSel = 3'b100; parityEn = ~par; twoStop = ~two;
          inData = ~d; inValid = 1'b1;
        end
        @(negedge clk);
      end
      check(!bad, $sformatf("%s %s pos %0d (line+2*ready)", tag, role, p), badAct, int'(expBit));
    end
    check(inReady === 1'b1 && txLine === 1'b1, {tag, " R2 ready/line after last stop"},
          int'(inReady) * 2 + int'(txLine), 3);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R1 line after reset", int'(txLine), 1);
    check(inReady === 1'b1, "R1 ready after reset", int'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testFixed();
    sendFrame(8'hA5, 3'b000, 8'd1, 1'b0, 1'b0, 1'b0, "R7 R6 fixed16");
    sendFrame(8'h3C, 3'b010, 8'd2, 1'b1, 1'b1, 1'b0, "R7 R6 fixed15");
    sendFrame(8'h01, 3'b100, 8'd0, 1'b1, 1'b0, 1'b0, "R7 fixed17");
  endtask

  task automatic testAlternate();
    sendFrame(8'h96, 3'b001, 8'd1, 1'b1, 1'b1, 1'b0, "R8 alt16/17");
    sendFrame(8'h5A, 3'b001, 8'd0, 1'b0, 1'b0, 1'b0, "R8 alt16/17 short");
    sendFrame(8'hE7, 3'b011, 8'd0, 1'b0, 1'b1, 1'b0, "R9 alt15/16");
    sendFrame(8'h80, 3'b011, 8'd2, 1'b1, 1'b0, 1'b0, "R9 alt15/16 parity");
  endtask

  task automatic testReserved();
    sendFrame(8'hC3, 3'b101, 8'd0, 1'b0, 1'b0, 1'b0, "R10 sel101");
    sendFrame(8'h7E, 3'b110, 8'd0, 1'b1, 1'b0, 1'b0, "R10 sel110");
    sendFrame(8'h11, 3'b111, 8'd1, 1'b0, 1'b1, 1'b0, "R10 sel111");
  endtask

  task automatic testBaudExample();
    // 15 ticks x 7 cycles = 105 cycles per bit: 4e6/105 ~ 38095 bit/s
    sendFrame(8'h55, 3'b010, 8'd6, 1'b0, 1'b0, 1'b0, "R6 105-cycle bit");
  endtask

  task automatic testBusyIgnore();
    sendFrame(8'h4B, 3'b001, 8'd1, 1'b0, 1'b0, 1'b1, "R11 R12 mid-frame changes");
    sendFrame(8'hF0, 3'b000, 8'd0, 1'b1, 1'b1, 1'b0, "R2 back-to-back");
  endtask

  initial begin
    testReset();
    testFixed();
    testAlternate();
    testReserved();
    testBaudExample();
    testBusyIgnore();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule